// File: doc/BRIEF.md
# Read-After-Write Interlock Stall Generator

This block is the hazard unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it decodes the opcode in the decode stage to find out which source registers that instruction actually reads. It also keeps its own record of the destination register and write-enable for the instructions now in execute, memory and writeback. A stall is raised only for a true read-after-write dependence. A source register counts only when the opcode reads it. A destination counts only when the opcode writes it and the register is not register zero.

While the stall is high, the program counter and the fetch/decode register are told to hold, and a bubble is put into execute. A bubble has its write-enable low. The execute, memory and writeback records keep moving forward every cycle, so an older producer drains out and the stall clears by itself. Reset fills every tracked stage with bubbles.

There is no state machine. The opcode kinds are an enumerated type, and a single `unique case` decodes them.

Top module: `raw_stall_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `stall` is 0 and all bits of `trk_wen` are 0.
- R2: The destination register recorded for an instruction is `dec_rd` for register-register ALU (opcode 0). It is `dec_rt` for ALU-immediate (1) and load (2). It is register 31 for jump-and-link (6) and jump-and-link-register (8). The record is visible on `trk_dst[4:0]` one cycle after the instruction sits in decode.
- R3: Opcodes 0, 1, 2, 6 and 8 set the recorded write-enable (`trk_wen[0]` one cycle later). Store (3), branch-on-zero (4), jump (5), jump-register (7) and the unused codes 9 to 15 leave it at 0.
- R4: The recorded write-enable is 0 whenever the destination register number is zero, and such an instruction never causes a stall.
- R5: The rs source is read by opcodes 0, 1, 2, 3, 4, 7 and 8. It is not read by opcodes 5, 6 or the unused codes.
- R6: The rt source is read only by opcodes 0 and 3.
- R7: `stall` is 1 in a cycle exactly when a read source of the decode instruction equals the destination of a write-enabled record in execute, memory or writeback. The rs term and the rt term are ORed.
- R8: While `stall` is 1, `pc_hold`, `fd_hold` and `ex_bubble` are 1. In the next cycle the execute record has write-enable 0, and the former execute record appears in memory.
- R9: A dependent register-register instruction directly after its producer is stalled for exactly three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_opc | input | 4 | Opcode kind of the decode-stage instruction |
| dec_rs | input | 5 | First source register field |
| dec_rt | input | 5 | Second source / immediate-form destination field |
| dec_rd | input | 5 | Register-form destination field |
| stall | output | 1 | Read-after-write interlock |
| pc_hold | output | 1 | Freeze program counter |
| fd_hold | output | 1 | Freeze fetch/decode register |
| ex_bubble | output | 1 | Insert no-op into execute |
| trk_wen | output | 3 | Write-enables of execute (bit 0), memory (bit 1), writeback (bit 2) |
| trk_dst | output | 15 | Destinations, 5 bits per stage, execute in bits 4:0 |

## Verification
`stall` and the three hold outputs are combinational from the decode fields and the tracked records. The bench reads them 1 ns after it drives new inputs on the falling edge, in the same cycle. The tracked records change on the rising edge, so a decode instruction shows in `trk_wen[0]`/`trk_dst[4:0]` one cycle later, in memory two cycles later and in writeback three cycles later. The bench reads those on the falling edge that follows each rising edge. Stall durations are counted one cycle at a time while the dependent instruction is held in decode. The count stops at the first cycle in which `stall` is low.

// File: rtl/raw_stall_pkg.sv
package raw_stall_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPK_ALU_RR    = 4'd0,
        OPK_ALU_IMM   = 4'd1,
        OPK_LOAD      = 4'd2,
        OPK_STORE     = 4'd3,
        OPK_BRZ       = 4'd4,
        OPK_JMP       = 4'd5,
        OPK_JLINK     = 4'd6,
        OPK_JREG      = 4'd7,
        OPK_JLINK_REG = 4'd8
    } opkind_e;
endpackage

// File: rtl/rs_op_decode.sv
module rs_op_decode
    import raw_stall_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] rs,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rd,
    output logic             rs_en,
    output logic             rt_en,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_dst
);
    localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

    logic raw_wen;
    logic unused_rs;

    assign unused_rs = ^rs;

    always_comb begin
        rs_en   = 1'b0;
        rt_en   = 1'b0;
        raw_wen = 1'b0;
        wr_dst  = '0;
        unique case (opc)
            OPK_ALU_RR:    begin rs_en = 1'b1; rt_en = 1'b1; raw_wen = 1'b1; wr_dst = rd; end
            OPK_ALU_IMM:   begin rs_en = 1'b1; raw_wen = 1'b1; wr_dst = rt; end
            OPK_LOAD:      begin rs_en = 1'b1; raw_wen = 1'b1; wr_dst = rt; end
            OPK_STORE:     begin rs_en = 1'b1; rt_en = 1'b1; end
            OPK_BRZ:       begin rs_en = 1'b1; end
            OPK_JMP:       begin end
            OPK_JLINK:     begin raw_wen = 1'b1; wr_dst = LINK_REG; end
            OPK_JREG:      begin rs_en = 1'b1; end
            OPK_JLINK_REG: begin rs_en = 1'b1; raw_wen = 1'b1; wr_dst = LINK_REG; end
            default:       begin end
        endcase
        wr_en = raw_wen && (wr_dst != '0);
    end
endmodule

// File: rtl/rs_stage_track.sv
module rs_stage_track #(
    parameter int REG_W = 5,
    parameter int DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bubble,
    input  logic                   in_wen,
    input  logic [REG_W-1:0]       in_dst,
    output logic [DEPTH-1:0]       out_wen,
    output logic [DEPTH*REG_W-1:0] out_dst
);
    logic [DEPTH-1:0] wen_q;
    logic [REG_W-1:0] dst_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q[0] <= 1'b0;
            dst_q[0] <= '0;
        end else if (bubble) begin
            wen_q[0] <= 1'b0;
            dst_q[0] <= '0;
        end else begin
            wen_q[0] <= in_wen;
            dst_q[0] <= in_dst;
        end
    end

    // R8
    bubble_enters_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !wen_q[0]);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_out
            assign out_wen[g]                 = wen_q[g];
            assign out_dst[g*REG_W +: REG_W]  = dst_q[g];

            // R4
            no_zero_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wen_q[g] |-> (dst_q[g] != '0));
        end
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wen_q[g] <= 1'b0;
                    dst_q[g] <= '0;
                end else begin
                    wen_q[g] <= wen_q[g-1];
                    dst_q[g] <= dst_q[g-1];
                end
            end

            // R8
            later_stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n && $past(rst_n) |-> (wen_q[g] == $past(wen_q[g-1])));
        end
    endgenerate
endmodule

// File: rtl/rs_hazard_cmp.sv
module rs_hazard_cmp #(
    parameter int REG_W = 5,
    parameter int DEPTH = 3
) (
    input  logic [REG_W-1:0]       src,
    input  logic                   src_en,
    input  logic [DEPTH-1:0]       stg_wen,
    input  logic [DEPTH*REG_W-1:0] stg_dst,
    output logic                   hit
);
    logic [DEPTH-1:0] match;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = stg_wen[g] && (stg_dst[g*REG_W +: REG_W] == src);
        end
    endgenerate

    assign hit = src_en && (|match);
endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit
    import raw_stall_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OPC_W-1:0]       dec_opc,
    input  logic [REG_W-1:0]       dec_rs,
    input  logic [REG_W-1:0]       dec_rt,
    input  logic [REG_W-1:0]       dec_rd,
    output logic                   stall,
    output logic                   pc_hold,
    output logic                   fd_hold,
    output logic                   ex_bubble,
    output logic [DEPTH-1:0]       trk_wen,
    output logic [DEPTH*REG_W-1:0] trk_dst
);
    logic             rs_en, rt_en, wr_en;
    logic [REG_W-1:0] wr_dst;
    logic             hit_rs, hit_rt;

    rs_op_decode #(.REG_W(REG_W)) u_dec (
        .opc(dec_opc), .rs(dec_rs), .rt(dec_rt), .rd(dec_rd),
        .rs_en(rs_en), .rt_en(rt_en), .wr_en(wr_en), .wr_dst(wr_dst)
    );

    rs_stage_track #(.REG_W(REG_W), .DEPTH(DEPTH)) u_trk (
        .clk(clk), .rst_n(rst_n), .bubble(stall),
        .in_wen(wr_en), .in_dst(wr_dst),
        .out_wen(trk_wen), .out_dst(trk_dst)
    );

    rs_hazard_cmp #(.REG_W(REG_W), .DEPTH(DEPTH)) u_cmp_rs (
        .src(dec_rs), .src_en(rs_en), .stg_wen(trk_wen), .stg_dst(trk_dst), .hit(hit_rs)
    );

    rs_hazard_cmp #(.REG_W(REG_W), .DEPTH(DEPTH)) u_cmp_rt (
        .src(dec_rt), .src_en(rt_en), .stg_wen(trk_wen), .stg_dst(trk_dst), .hit(hit_rt)
    );

    assign stall     = hit_rs | hit_rt;
    assign pc_hold   = stall;
    assign fd_hold   = stall;
    assign ex_bubble = stall;

    // R7
    stall_needs_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (|trk_wen));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (trk_wen == '0));

    // R5
    jump_reads_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_opc == OPK_JMP) || (dec_opc == OPK_JLINK)) |-> !stall);
endmodule

// File: tb/raw_stall_unit_tb.sv
`timescale 1ns/1ps
module raw_stall_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  dec_opc;
    logic [4:0]  dec_rs, dec_rt, dec_rd;
    logic        stall, pc_hold, fd_hold, ex_bubble;
    logic [2:0]  trk_wen;
    logic [14:0] trk_dst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    raw_stall_unit u_dut (
        .clk(clk), .rst_n(rst_n), .dec_opc(dec_opc), .dec_rs(dec_rs),
        .dec_rt(dec_rt), .dec_rd(dec_rd), .stall(stall), .pc_hold(pc_hold),
        .fd_hold(fd_hold), .ex_bubble(ex_bubble), .trk_wen(trk_wen), .trk_dst(trk_dst)
    );

    // entry: {opcode, exp_wen, exp_dst, rs_read, rt_read}; fields rs=3 rt=7 rd=11
    localparam logic [11:0] VEC [10] = '{
        {4'd0,  1'b1, 5'd11, 1'b1, 1'b1},
        {4'd1,  1'b1, 5'd7,  1'b1, 1'b0},
        {4'd2,  1'b1, 5'd7,  1'b1, 1'b0},
        {4'd3,  1'b0, 5'd0,  1'b1, 1'b1},
        {4'd4,  1'b0, 5'd0,  1'b1, 1'b0},
        {4'd5,  1'b0, 5'd0,  1'b0, 1'b0},
        {4'd6,  1'b1, 5'd31, 1'b0, 1'b0},
        {4'd7,  1'b0, 5'd0,  1'b1, 1'b0},
        {4'd8,  1'b1, 5'd31, 1'b1, 1'b0},
        {4'd12, 1'b0, 5'd0,  1'b0, 1'b0}
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [4:0] s, input logic [4:0] t, input logic [4:0] d);
        dec_opc = o; dec_rs = s; dec_rt = t; dec_rd = d;
    endtask

    task automatic flush();
        drive(4'd5, 5'd0, 5'd0, 5'd0);
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (R1..R9 unfinished): actual %0d expected 0", cyc);
            summary();
        end
    end

    initial begin
        int k;
        rst_n = 1'b0;
        drive(4'd0, 5'd1, 5'd1, 5'd1);
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state even with a writer in decode
        chk("R1 stall", stall, 0);
        chk("R1 trk_wen", trk_wen, 0);
        drive(4'd5, 5'd0, 5'd0, 5'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", trk_wen, 0);

        for (int i = 0; i < 10; i++) begin
            flush();
            drive(VEC[i][11:8], 5'd3, 5'd7, 5'd11);
            #1 chk("R7 empty pipe", stall, 0);
            @(negedge clk);
            chk("R3 write enable", trk_wen[0], VEC[i][7]);
            if (VEC[i][7]) chk("R2 destination", trk_dst[4:0], VEC[i][6:2]);
            flush();
            drive(4'd1, 5'd0, 5'd5, 5'd0);
            @(negedge clk);
            drive(VEC[i][11:8], 5'd5, 5'd9, 5'd9);
            #1 chk("R5 rs read", stall, VEC[i][1]);
            @(negedge clk);
            flush();
            drive(4'd1, 5'd0, 5'd5, 5'd0);
            @(negedge clk);
            drive(VEC[i][11:8], 5'd9, 5'd5, 5'd9);
            #1 chk("R6 rt read", stall, VEC[i][0]);
            @(negedge clk);
        end

        // R9 back-to-back dependent pair
        flush();
        drive(4'd0, 5'd2, 5'd3, 5'd1);
        @(negedge clk);
        drive(4'd0, 5'd1, 5'd6, 5'd4);
        k = 0;
        #1;
        while (stall && k < 10) begin
            k++;
            if (k == 1) begin
                chk("R8 pc_hold", pc_hold, 1);
                chk("R8 fd_hold", fd_hold, 1);
                chk("R8 ex_bubble", ex_bubble, 1);
            end
            @(negedge clk);
            if (k == 1) begin
                chk("R8 bubble in execute", trk_wen[0], 0);
                chk("R8 producer in memory", trk_wen[1], 1);
                chk("R8 memory destination", trk_dst[9:5], 1);
            end
            #1;
        end
        chk("R9 stall cycles", k, 3);
        @(negedge clk);

        // R7 rt match two stages back
        flush();
        drive(4'd1, 5'd0, 5'd8, 5'd0);
        @(negedge clk);
        drive(4'd5, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        drive(4'd3, 5'd0, 5'd8, 5'd0);
        k = 0;
        #1;
        while (stall && k < 10) begin
            k++;
            @(negedge clk);
            #1;
        end
        chk("R7 rt via memory stage", k, 2);
        @(negedge clk);

        // R7 independent pair
        flush();
        drive(4'd0, 5'd2, 5'd3, 5'd1);
        @(negedge clk);
        drive(4'd0, 5'd4, 5'd5, 5'd6);
        #1 chk("R7 independent", stall, 0);
        @(negedge clk);

        // R4 write to register zero
        flush();
        drive(4'd0, 5'd2, 5'd3, 5'd0);
        @(negedge clk);
        chk("R4 zero dest wen", trk_wen[0], 0);
        drive(4'd0, 5'd0, 5'd0, 5'd2);
        #1 chk("R4 zero no stall", stall, 0);
        @(negedge clk);
        drive(4'd1, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        chk("R4 immediate to zero", trk_wen[0], 0);
        drive(4'd5, 5'd0, 5'd0, 5'd0);
        @(negedge clk);

        summary();
    end
endmodule